// File: doc/BRIEF.md
# Turn and Hazard Tail-Light Sequencer

This block drives the three rear lamps on each side of a vehicle. A left or right turn request produces a three-step chase on that side: the inner lamp lights first, then the middle lamp joins, then the outer lamp joins. After that all lamps go dark for one step. A hazard request flashes all six lamps together. A request for both turns at once is treated the same way as a hazard request.

The block is a clocked Moore machine with eight states held in three state bits. The lamp outputs are decoded from the state alone. The clock is expected to run at the flash rate, which is produced elsewhere. Hazard takes over at once if it arrives during the first or second step of a chase. It does not wait for the chase to finish. The last chase step, and the all-lamps step, always return to the dark state on the next clock.

Top module: `taillight_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine enters its idle state, and after that edge all six lamp outputs are 0.
- R2: In idle, with no turn or hazard request, the machine stays idle and all lamps stay off.
- R3: From idle, a left request without right and without hazard starts the left chase. On `lamp_left_o` (bit 0 = inner, bit 2 = outer) the patterns are 3'b001, 3'b011 and 3'b111 on successive clocks, then 3'b000. `lamp_right_o` stays 3'b000 throughout.
- R4: From idle, a right request without left and without hazard produces the same chase on `lamp_right_o` (bit 0 = inner). `lamp_left_o` stays 3'b000 throughout.
- R5: From idle, a hazard request, or left and right requested together, lights all six lamps (3'b111 on both sides) on the next clock. All lamps then go off on the following clock, whatever the inputs are.
- R6: If hazard is high during the first or second step of either chase, all six lamps are lit after the next clock.
- R7: After the third chase step, the next clock always returns the machine to idle with all lamps off, even when hazard or a turn request is high.
- R8: During the first or second chase step with hazard low, the turn inputs have no effect, and the chase moves on to its next step.
- R9: At every clock, at most one side shows a non-zero pattern, except in the all-six-lamps pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Flash-rate clock, rising edge |
| rst | input | 1 | Synchronous reset to idle, active high |
| turn_left_i | input | 1 | Left turn request |
| turn_right_i | input | 1 | Right turn request |
| hazard_i | input | 1 | Hazard request |
| lamp_left_o | output | 3 | Left lamps; bit 0 inner, bit 2 outer |
| lamp_right_o | output | 3 | Right lamps; bit 0 inner, bit 2 outer |

## Verification
The assertions assume the three request inputs are sampled only at the rising edge and are stable around it. They also assume the inputs can take any combination, so there is no one-hot constraint. Under that assumption, an illegal request mix must never make the machine leave its legal lamp patterns. The stimulus changes the inputs only on the falling edge. It deliberately covers overlapping requests: both turns together, hazard combined with a turn, and a turn input flipping in the middle of a chase. This exercises every arc out of idle and every pre-emption point.

// File: rtl/tl_pkg.sv
package tl_pkg;

  localparam int LAMPS  = 3;
  localparam int SIDES  = 2;
  localparam int STW    = 3;
  localparam int POSW   = STW - 1;

  // bit 2 marks the right side; bits 1:0 count the chase in Gray order
  typedef enum logic [STW-1:0] {
    ST_IDLE = 3'b000,
    ST_L1   = 3'b001,
    ST_L2   = 3'b011,
    ST_L3   = 3'b010,
    ST_ALL  = 3'b100,
    ST_R1   = 3'b101,
    ST_R2   = 3'b111,
    ST_R3   = 3'b110
  } tl_state_e;

  typedef struct packed {
    logic want_all;
    logic want_left;
    logic want_right;
    logic haz;
  } tl_req_t;

  localparam logic [POSW-1:0] POS_REST  = 2'b00;
  localparam logic [POSW-1:0] POS_LAST  = 2'b10;

  // sort raw inputs into exactly one of: all, left, right or none
  function automatic tl_req_t tl_classify(input logic l, input logic r, input logic h);
    tl_req_t q;
    q.haz        = h;
    q.want_all   = h | (l & r);
    q.want_left  = l & ~r & ~h;
    q.want_right = r & ~l & ~h;
    return q;
  endfunction

  // advance one step through the Gray chase 00 -> 01 -> 11 -> 10 -> 00
  function automatic logic [POSW-1:0] tl_gray_step(input logic [POSW-1:0] p);
    logic [POSW-1:0] n;
    case (p)
      2'b00:   n = 2'b01;
      2'b01:   n = 2'b11;
      2'b11:   n = 2'b10;
      default: n = 2'b00;
    endcase
    return n;
  endfunction

  // lamp bar lit for a chase position: grows from the inner lamp outward
  function automatic logic [LAMPS-1:0] tl_bar(input logic [POSW-1:0] p);
    logic [LAMPS-1:0] b;
    case (p)
      2'b01:   b = 3'b001;
      2'b11:   b = 3'b011;
      2'b10:   b = 3'b111;
      default: b = 3'b000;
    endcase
    return b;
  endfunction

  // first or second chase step (either side)
  function automatic logic tl_mid_chase(input tl_state_e s);
    logic [STW-1:0] c;
    c = s;
    return c[0];
  endfunction

endpackage

// File: rtl/tl_request_decode.sv
module tl_request_decode
  import tl_pkg::*;
(
  input  logic    turn_left_i,
  input  logic    turn_right_i,
  input  logic    hazard_i,
  output tl_req_t req_o
);

  always_comb begin
    req_o = tl_classify(turn_left_i, turn_right_i, hazard_i);
  end

endmodule

// File: rtl/tl_next_state.sv
module tl_next_state
  import tl_pkg::*;
(
  input  tl_state_e state_i,
  input  tl_req_t   req_i,
  output tl_state_e next_o,
  output logic      preempt_o,
  output logic      chase_done_o
);

  logic [STW-1:0]  code;
  logic [POSW-1:0] pos;
  logic            side_r;

  assign code   = state_i;
  assign pos    = code[POSW-1:0];
  assign side_r = code[STW-1];

  assign preempt_o    = tl_mid_chase(state_i) & req_i.haz;
  assign chase_done_o = (state_i != ST_ALL) && (pos == POS_LAST);

  always_comb begin
    next_o = ST_IDLE;
    if (state_i == ST_IDLE) begin
      if (req_i.want_all)        next_o = ST_ALL;
      else if (req_i.want_left)  next_o = ST_L1;
      else if (req_i.want_right) next_o = ST_R1;
      else                       next_o = ST_IDLE;
    end else if (state_i == ST_ALL) begin
      next_o = ST_IDLE;
    end else if (pos == POS_LAST) begin
      next_o = ST_IDLE;
    end else if (req_i.haz) begin
      next_o = ST_ALL;
    end else begin
      next_o = tl_state_e'({side_r, tl_gray_step(pos)});
    end
  end

endmodule

// File: rtl/tl_state_reg.sv
module tl_state_reg
  import tl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  tl_state_e next_i,
  output tl_state_e state_o
);

  always_ff @(posedge clk) begin
    if (rst) state_o <= ST_IDLE;
    else     state_o <= next_i;
  end

endmodule

// File: rtl/tl_lamp_drive.sv
module tl_lamp_drive
  import tl_pkg::*;
(
  input  tl_state_e        state_i,
  output logic [LAMPS-1:0] lamp_left_o,
  output logic [LAMPS-1:0] lamp_right_o
);

  logic [STW-1:0]             code;
  logic [LAMPS-1:0]           bar;
  logic                       all_on;
  logic [SIDES-1:0][LAMPS-1:0] side_lamps;

  assign code   = state_i;
  assign all_on = (state_i == ST_ALL);
  assign bar    = tl_bar(code[POSW-1:0]);

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic this_side;
    assign this_side = (code[STW-1] == s[0]);
    assign side_lamps[s] = all_on ? {LAMPS{1'b1}} : (this_side ? bar : '0);
  end

  assign lamp_left_o  = side_lamps[0];
  assign lamp_right_o = side_lamps[1];

endmodule

// File: rtl/taillight_seq.sv
module taillight_seq
  import tl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             turn_left_i,
  input  logic             turn_right_i,
  input  logic             hazard_i,
  output logic [LAMPS-1:0] lamp_left_o,
  output logic [LAMPS-1:0] lamp_right_o
);

  tl_req_t   req;
  tl_state_e state_q;
  tl_state_e state_d;
  logic      haz_preempt;
  logic      chase_done;

  tl_request_decode u_req (
    .turn_left_i (turn_left_i),
    .turn_right_i(turn_right_i),
    .hazard_i    (hazard_i),
    .req_o       (req)
  );

  tl_next_state u_next (
    .state_i     (state_q),
    .req_i       (req),
    .next_o      (state_d),
    .preempt_o   (haz_preempt),
    .chase_done_o(chase_done)
  );

  tl_state_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .next_i (state_d),
    .state_o(state_q)
  );

  tl_lamp_drive u_lamp (
    .state_i     (state_q),
    .lamp_left_o (lamp_left_o),
    .lamp_right_o(lamp_right_o)
  );

endmodule

// File: rtl/tl_checker.sv
module tl_checker (
  input logic       clk,
  input logic       rst,
  input logic       left_i,
  input logic       right_i,
  input logic       haz_i,
  input logic [2:0] lamp_l,
  input logic [2:0] lamp_r,
  input logic       preempt,
  input logic       chase_done
);

  logic dark, full;
  assign dark = (lamp_l == 3'b000) && (lamp_r == 3'b000);
  assign full = (lamp_l == 3'b111) && (lamp_r == 3'b111);

  p_reset_dark_r1: assert property (@(posedge clk) rst |=> dark);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (dark && !left_i && !right_i && !haz_i) |=> dark);

  p_left_adv_r3: assert property (@(posedge clk) disable iff (rst)
    (lamp_l == 3'b001 && lamp_r == 3'b000 && !haz_i) |=> (lamp_l == 3'b011 && lamp_r == 3'b000));

  p_right_adv_r4: assert property (@(posedge clk) disable iff (rst)
    (lamp_r == 3'b001 && lamp_l == 3'b000 && !haz_i) |=> (lamp_r == 3'b011 && lamp_l == 3'b000));

  p_idle_hazard_r5: assert property (@(posedge clk) disable iff (rst)
    (dark && (haz_i || (left_i && right_i))) |=> full);

  p_full_ends_r5: assert property (@(posedge clk) disable iff (rst)
    full |=> dark);

  p_preempt_r6: assert property (@(posedge clk) disable iff (rst)
    preempt |=> full);

  p_chase_end_r7: assert property (@(posedge clk) disable iff (rst)
    chase_done |=> dark);

  p_one_side_r9: assert property (@(posedge clk) disable iff (rst)
    full || lamp_l == 3'b000 || lamp_r == 3'b000);

endmodule

bind taillight_seq tl_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .left_i    (turn_left_i),
  .right_i   (turn_right_i),
  .haz_i     (hazard_i),
  .lamp_l    (lamp_left_o),
  .lamp_r    (lamp_right_o),
  .preempt   (haz_preempt),
  .chase_done(chase_done)
);

// File: tb/taillight_seq_tb.sv
module taillight_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tl = 1'b0, tr = 1'b0, hz = 1'b0;
  logic [2:0] lamp_l, lamp_r;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  // reference model: mode 0 dark, 1 left chase, 2 right chase, 3 all lamps
  int m_mode = 0;
  int m_step = 0;

  always #2 clk = ~clk;

  taillight_seq u_dut (
    .clk(clk), .rst(rst),
    .turn_left_i(tl), .turn_right_i(tr), .hazard_i(hz),
    .lamp_left_o(lamp_l), .lamp_right_o(lamp_r)
  );

  function automatic logic [2:0] bar_of(int step);
    if (step == 1) return 3'b001;
    if (step == 2) return 3'b011;
    if (step == 3) return 3'b111;
    return 3'b000;
  endfunction

  function automatic logic [5:0] model_lamps();
    if (m_mode == 3) return 6'b111111;
    if (m_mode == 1) return {3'b000, bar_of(m_step)};
    if (m_mode == 2) return {bar_of(m_step), 3'b000};
    return 6'b000000;
  endfunction

  task automatic model_clock(input bit r, input bit l, input bit rq, input bit h);
    if (r) begin
      m_mode = 0; m_step = 0;
    end else if (m_mode == 0) begin
      if (h || (l && rq))  begin m_mode = 3; m_step = 0; end
      else if (l)          begin m_mode = 1; m_step = 1; end
      else if (rq)         begin m_mode = 2; m_step = 1; end
    end else if (m_mode == 3) begin
      m_mode = 0;
    end else if (m_step == 3) begin
      m_mode = 0; m_step = 0;
    end else if (h) begin
      m_mode = 3; m_step = 0;
    end else begin
      m_step = m_step + 1;
    end
  endtask

  // driver: set inputs on the falling edge, queue the pattern expected after the next rising edge
  task automatic drive(input bit r, input bit l, input bit rq, input bit h, input string tag);
    @(negedge clk);
    rst = r; tl = l; tr = rq; hz = h;
    model_clock(r, l, rq, h);
    exp_q.push_back(model_lamps());
    tag_q.push_back(tag);
  endtask

  // monitor: sample shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [5:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if ({lamp_r, lamp_l} !== e) begin
          n_fail++;
          $display("FAIL %s: lamps R/L actual %b_%b expected %b_%b", t, lamp_r, lamp_l, e[5:3], e[2:0]);
        end
        // R9: only one side lit unless all six are lit
        n_checks++;
        if (!({lamp_r, lamp_l} == 6'b111111 || lamp_l == 3'b000 || lamp_r == 3'b000)) begin
          n_fail++;
          $display("FAIL R9: lamps R/L actual %b_%b expected one side dark or all lit", lamp_r, lamp_l);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    drive(1, 0, 0, 0, "R1");
    drive(1, 1, 1, 1, "R1");
    // R2 idle holds
    drive(0, 0, 0, 0, "R2");
    drive(0, 0, 0, 0, "R2");
    // R3 left chase with left held
    drive(0, 1, 0, 0, "R3");
    drive(0, 1, 0, 0, "R3");
    drive(0, 1, 0, 0, "R3");
    drive(0, 1, 0, 0, "R3");
    drive(0, 0, 0, 0, "R3");
    // R4 right chase
    drive(0, 0, 1, 0, "R4");
    drive(0, 0, 0, 0, "R4");
    drive(0, 0, 0, 0, "R4");
    drive(0, 0, 0, 0, "R4");
    // R5 hazard from idle, both turns as hazard, held hazard
    drive(0, 0, 0, 1, "R5");
    drive(0, 1, 0, 1, "R5");
    drive(0, 1, 1, 0, "R5");
    drive(0, 0, 0, 0, "R5");
    drive(0, 0, 0, 1, "R5");
    drive(0, 0, 0, 1, "R5");
    drive(0, 0, 0, 1, "R5");
    drive(0, 0, 0, 0, "R5");
    // R6 pre-emption at each mid-chase step
    drive(0, 1, 0, 0, "R6");
    drive(0, 0, 0, 1, "R6");
    drive(0, 0, 0, 0, "R6");
    drive(0, 1, 0, 0, "R6");
    drive(0, 0, 0, 0, "R6");
    drive(0, 0, 0, 1, "R6");
    drive(0, 0, 0, 0, "R6");
    drive(0, 0, 1, 0, "R6");
    drive(0, 0, 1, 1, "R6");
    drive(0, 0, 0, 0, "R6");
    drive(0, 0, 1, 0, "R6");
    drive(0, 0, 0, 0, "R6");
    drive(0, 1, 1, 1, "R6");
    drive(0, 0, 0, 0, "R6");
    // R7 last step ignores hazard and turns
    drive(0, 1, 0, 0, "R7");
    drive(0, 0, 0, 0, "R7");
    drive(0, 0, 0, 0, "R7");
    drive(0, 1, 1, 1, "R7");
    drive(0, 0, 0, 0, "R7");
    drive(0, 0, 1, 0, "R7");
    drive(0, 0, 0, 0, "R7");
    drive(0, 0, 0, 0, "R7");
    drive(0, 0, 1, 1, "R7");
    drive(0, 0, 0, 0, "R7");
    // R8 turn inputs ignored mid-chase without hazard
    drive(0, 1, 0, 0, "R8");
    drive(0, 0, 1, 0, "R8");
    drive(0, 1, 1, 0, "R8");
    drive(0, 0, 0, 0, "R8");
    drive(0, 0, 1, 0, "R8");
    drive(0, 1, 0, 0, "R8");
    drive(0, 1, 1, 0, "R8");
    drive(0, 0, 0, 0, "R8");
    // R1 reset in the middle of a chase and during all-on
    drive(0, 1, 0, 0, "R1");
    drive(0, 0, 0, 0, "R1");
    drive(1, 0, 0, 0, "R1");
    drive(0, 0, 0, 1, "R1");
    drive(1, 0, 0, 1, "R1");
    drive(0, 0, 0, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule